// File: doc/BRIEF.md
# Multithread Issue Slot Allocator

This block shares the functional units of a simultaneously multithreaded core among its hardware thread contexts. In every cycle each context reports how many of its instructions are ready to issue. The allocator then hands out the free units in a fixed order of precedence. The lowest-numbered context is served first. Each later context may only take units that every context ahead of it left unclaimed.

Two controls limit what a context may receive. A per-context width code caps how many units that context may take in one cycle. A partitioned-connection mode restricts each unit to one fixed pair of contexts. A per-unit busy input withdraws a unit from the cycle's allocation.

The per-context granted counts are produced combinationally from the current inputs. The per-unit grant view is registered. It consists of a valid flag and the owning context number for each unit.

Top module: `issue_slot_allocator`

## Requirements
- R1: A synchronous active-low reset clears every unit valid flag and every unit thread ID to zero at the clock edge that samples reset low.
- R2: Contexts are served in ascending number. Context t is granted min(its request, its cap, the number of units eligible to it that contexts 0..t-1 did not take). Requests are 4-bit counts.
- R3: The 2-bit per-context cap code means: 0 gives 8 units, 1 gives 4 units, 2 gives 2 units, 3 gives 1 unit. The code for context t sits in bits [2t+1:2t] of the cap input.
- R4: Within its eligible free units, a context receives the lowest-numbered units first.
- R5: A unit whose busy bit is set is never granted. Its registered valid flag is low in the following cycle.
- R6: When partitioned mode is high, unit u can be granted only to contexts 2*(u mod 4) and 2*(u mod 4)+1. Of that pair, the lower-numbered context still has precedence.
- R7: No unit is granted to two contexts in one cycle. The total number of grants never exceeds the number of non-busy units.
- R8: The granted counts reflect the current inputs in the same cycle. Bits [4t+3:4t] hold context t's count. The unit valid flags and 3-bit thread IDs (bits [3u+2:3u] for unit u) show the allocation of the inputs sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_cnt_i | input | 32 | Ready-instruction count per context, 4 bits each |
| cap_code_i | input | 16 | Issue cap code per context, 2 bits each |
| limited_mode_i | input | 1 | Partitioned unit-to-context connection mode |
| unit_busy_i | input | 8 | Unit withdrawn from allocation this cycle |
| grant_cnt_o | output | 32 | Units granted per context this cycle, 4 bits each |
| unit_vld_o | output | 8 | Registered: unit was granted last cycle |
| unit_tid_o | output | 24 | Registered: owning context per unit, 3 bits each |

## Verification
The assertions assume that the request, cap, mode and busy inputs are known, settled values at each rising edge. They also assume that a request above the unit count behaves like a request for all units. The stimulus changes inputs only just after a rising edge. It draws requests from 0 to 8 and exercises every cap code and both connection modes. Busy patterns range from none to all. Resets are applied at the start of the run and once in the middle of it, so the reset checks see a design that already holds grants.

// File: rtl/issue_alloc_pkg.sv
// Shared constants and helpers for the issue slot allocator.
// Assumes cap codes are two bits wide; every code maps to a power-of-two width.
package issue_alloc_pkg;

    localparam int CAP_CODE_W = 2;

    // Convert a cap code into the maximum number of units per cycle.
    function automatic int unsigned cap_limit(input logic [CAP_CODE_W-1:0] code);
        int unsigned lim;
        case (code)
            2'd0:    lim = 8;
            2'd1:    lim = 4;
            2'd2:    lim = 2;
            default: lim = 1;
        endcase
        return lim;
    endfunction

    // Smaller of two unsigned counts.
    function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/unit_conn_map.sv
// Builds the per-context mask of units each context is allowed to reach.
// Full mode: every context reaches every unit.
// Partitioned mode: contexts are grouped in pairs, and unit u belongs to
// pair (u mod NUM_PAIRS).
// Assumes NUM_THREADS is even.
module unit_conn_map #(
    parameter int NUM_THREADS = 8,
    parameter int NUM_UNITS   = 8
) (
    input  logic                                  limited_mode,
    output logic [NUM_THREADS-1:0][NUM_UNITS-1:0] conn_mask
);
    localparam int NUM_PAIRS = NUM_THREADS / 2;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
            localparam bit IN_PAIR = ((u % NUM_PAIRS) == (t / 2));
            // Reachability of unit u by context t under the selected mode.
            always_comb conn_mask[t][u] = limited_mode ? IN_PAIR : 1'b1;
        end
    end

endmodule

// File: rtl/thread_slot_picker.sv
// One stage of the priority chain. It takes the units left over by
// higher-precedence contexts and claims up to min(request, cap) of the
// eligible ones, lowest-numbered first. It passes on what remains.
// Assumes avail_in already excludes busy units and earlier claims.
module thread_slot_picker
    import issue_alloc_pkg::*;
#(
    parameter int NUM_UNITS = 8,
    parameter int CNT_W     = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_UNITS-1:0]  avail_in,
    input  logic [NUM_UNITS-1:0]  conn_in,
    input  logic [CNT_W-1:0]      req_in,
    input  logic [CAP_CODE_W-1:0] cap_code,
    output logic [NUM_UNITS-1:0]  grant,
    output logic [CNT_W-1:0]      grant_cnt,
    output logic [NUM_UNITS-1:0]  avail_out
);
    logic [NUM_UNITS-1:0] eligible;
    int unsigned          limit;
    int unsigned          taken;

    // Units this context could use this cycle.
    always_comb eligible = avail_in & conn_in;

    // Claim the lowest eligible units up to the per-cycle limit.
    always_comb begin
        limit = min_u(int'(req_in), cap_limit(cap_code));
        taken = 0;
        grant = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (eligible[u] && (taken < limit)) begin
                grant[u] = 1'b1;
                taken    = taken + 1;
            end
        end
        grant_cnt = CNT_W'(taken);
    end

    // Hand the unclaimed units on to the next context.
    always_comb avail_out = avail_in & ~grant;

    // R3
    cap_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) <= cap_limit(cap_code));

    // R2
    fill_when_possible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(grant) < int'(req_in) && $countones(grant) < cap_limit(cap_code))
            |-> ((avail_out & conn_in) == '0));

endmodule

// File: rtl/unit_grant_reg.sv
// Turns the context-by-unit grant matrix into a registered per-unit view:
// a valid flag and the number of the owning context.
// Assumes each unit column of the matrix has at most one bit set.
module unit_grant_reg #(
    parameter int NUM_THREADS = 8,
    parameter int NUM_UNITS   = 8,
    parameter int TID_W       = 3
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_THREADS-1:0][NUM_UNITS-1:0] grant_mtx,
    output logic [NUM_UNITS-1:0]                  unit_vld_q,
    output logic [NUM_UNITS-1:0][TID_W-1:0]       unit_tid_q
);
    logic [NUM_UNITS-1:0]                  unit_vld_d;
    logic [NUM_UNITS-1:0][TID_W-1:0]       unit_tid_d;
    logic [NUM_UNITS-1:0][NUM_THREADS-1:0] column;

    // Transpose the matrix so that each unit sees its owners.
    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++)
            for (int t = 0; t < NUM_THREADS; t++)
                column[u][t] = grant_mtx[t][u];
    end

    // Encode the owner of each unit.
    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++) begin
            unit_vld_d[u] = |column[u];
            unit_tid_d[u] = '0;
            for (int t = 0; t < NUM_THREADS; t++)
                if (column[u][t]) unit_tid_d[u] = TID_W'(t);
        end
    end

    // Register the per-unit view, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_vld_q <= '0;
            unit_tid_q <= '0;
        end else begin
            unit_vld_q <= unit_vld_d;
            unit_tid_q <= unit_tid_d;
        end
    end

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
        // R7
        single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(column[u]));
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (unit_vld_q == '0 && unit_tid_q == '0));

endmodule

// File: rtl/issue_slot_allocator.sv
// Top level of the issue slot allocator. It chains one picker per context
// in precedence order, so each context sees only the units its
// predecessors left. The resulting grants go to a registered per-unit view.
// Assumes requests above NUM_UNITS behave as requests for every unit.
module issue_slot_allocator
    import issue_alloc_pkg::*;
#(
    parameter int NUM_THREADS = 8,
    parameter int NUM_UNITS   = 8
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [NUM_THREADS*$clog2(NUM_UNITS+1)-1:0] req_cnt_i,
    input  logic [NUM_THREADS*2-1:0]                  cap_code_i,
    input  logic                                      limited_mode_i,
    input  logic [NUM_UNITS-1:0]                      unit_busy_i,
    output logic [NUM_THREADS*$clog2(NUM_UNITS+1)-1:0] grant_cnt_o,
    output logic [NUM_UNITS-1:0]                      unit_vld_o,
    output logic [NUM_UNITS*$clog2(NUM_THREADS)-1:0]  unit_tid_o
);
    localparam int CNT_W     = $clog2(NUM_UNITS + 1);
    localparam int TID_W     = $clog2(NUM_THREADS);
    localparam int NUM_PAIRS = NUM_THREADS / 2;

    logic [NUM_THREADS-1:0][NUM_UNITS-1:0] conn_mask;
    logic [NUM_THREADS:0][NUM_UNITS-1:0]   avail_chain;
    logic [NUM_THREADS-1:0][NUM_UNITS-1:0] grant_mtx;
    logic [NUM_UNITS-1:0][TID_W-1:0]       unit_tid_q;

    // The free pool entering the chain excludes busy units.
    always_comb avail_chain[0] = ~unit_busy_i;

    unit_conn_map #(
        .NUM_THREADS(NUM_THREADS),
        .NUM_UNITS  (NUM_UNITS)
    ) u_conn (
        .limited_mode(limited_mode_i),
        .conn_mask   (conn_mask)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_pick
        thread_slot_picker #(
            .NUM_UNITS(NUM_UNITS),
            .CNT_W    (CNT_W)
        ) u_pick (
            .clk      (clk),
            .rst_n    (rst_n),
            .avail_in (avail_chain[t]),
            .conn_in  (conn_mask[t]),
            .req_in   (req_cnt_i[t*CNT_W +: CNT_W]),
            .cap_code (cap_code_i[t*2 +: 2]),
            .grant    (grant_mtx[t]),
            .grant_cnt(grant_cnt_o[t*CNT_W +: CNT_W]),
            .avail_out(avail_chain[t+1])
        );
    end

    unit_grant_reg #(
        .NUM_THREADS(NUM_THREADS),
        .NUM_UNITS  (NUM_UNITS),
        .TID_W      (TID_W)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant_mtx (grant_mtx),
        .unit_vld_q(unit_vld_o),
        .unit_tid_q(unit_tid_q)
    );

    // Flatten the registered thread IDs onto the output port.
    always_comb unit_tid_o = unit_tid_q;

    // R7
    total_within_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_mtx) <= $countones(~unit_busy_i));

    // R2
    head_ctx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!limited_mode_i) |-> (int'(grant_cnt_o[CNT_W-1:0]) ==
            min_u(min_u(int'(req_cnt_i[CNT_W-1:0]), cap_limit(cap_code_i[1:0])),
                  $countones(~unit_busy_i))));

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit_chk
        // R5
        busy_not_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
            unit_busy_i[u] |=> !unit_vld_o[u]);

        // R6
        pair_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
            limited_mode_i |=> (!unit_vld_o[u] ||
                (int'(unit_tid_q[u]) / 2) == (u % NUM_PAIRS)));
    end

endmodule

// File: tb/sim_issue_slot_allocator.sv
// Self-checking bench with a behavioural per-cycle reference model.
module sim_issue_slot_allocator;
    localparam int NT = 8;
    localparam int NU = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT*4-1:0] req_cnt = '0;
    logic [NT*2-1:0] cap_code = '0;
    logic          limited = 1'b0;
    logic [NU-1:0] busy = '0;
    logic [NT*4-1:0] grant_cnt;
    logic [NU-1:0] unit_vld;
    logic [NU*3-1:0] unit_tid;

    int checks = 0;
    int errors = 0;

    logic [NT*4-1:0] exp_cnt;
    logic [NU-1:0]   exp_vld;
    logic [NU*3-1:0] exp_tid;

    always #2 clk = ~clk;

    issue_slot_allocator u0 (
        .clk(clk), .rst_n(rst_n), .req_cnt_i(req_cnt), .cap_code_i(cap_code),
        .limited_mode_i(limited), .unit_busy_i(busy), .grant_cnt_o(grant_cnt),
        .unit_vld_o(unit_vld), .unit_tid_o(unit_tid)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference: walk contexts in order, each taking lowest free reachable units.
    task automatic model();
        bit free [NU];
        int cap;
        int lim;
        int taken;
        exp_cnt = '0; exp_vld = '0; exp_tid = '0;
        for (int u = 0; u < NU; u++) free[u] = !busy[u];
        for (int t = 0; t < NT; t++) begin
            case (cap_code[t*2 +: 2])
                2'd0: cap = 8; 2'd1: cap = 4; 2'd2: cap = 2; default: cap = 1;
            endcase
            lim = int'(req_cnt[t*4 +: 4]);
            if (cap < lim) lim = cap;
            taken = 0;
            for (int u = 0; u < NU; u++) begin
                if (free[u] && (!limited || (u % 4) == (t / 2)) && taken < lim) begin
                    free[u] = 0;
                    exp_vld[u] = 1'b1;
                    exp_tid[u*3 +: 3] = 3'(t);
                    taken++;
                end
            end
            exp_cnt[t*4 +: 4] = 4'(taken);
        end
    endtask

    // Inputs are already set; check same-cycle counts, then the registered view.
    task automatic run(input string tag);
        #1;
        model();
        if (rst_n) check(tag, "grant_cnt R8", 64'(grant_cnt), 64'(exp_cnt));
        @(posedge clk);
        #1;
        if (!rst_n) begin
            check("R1", "unit_vld", 64'(unit_vld), 64'd0);
            check("R1", "unit_tid", 64'(unit_tid), 64'd0);
        end else begin
            check(tag, "unit_vld", 64'(unit_vld), 64'(exp_vld));
            check(tag, "unit_tid", 64'(unit_tid), 64'(exp_tid));
        end
    endtask

    function automatic logic [NT*4-1:0] all_req(input int n);
        logic [NT*4-1:0] v;
        for (int t = 0; t < NT; t++) v[t*4 +: 4] = 4'(n);
        return v;
    endfunction

    initial begin
        // R1: reset state
        @(posedge clk); #1;
        req_cnt = all_req(8);
        run("R1");
        rst_n = 1'b1;

        // R2: context 0 takes everything, the rest get nothing
        req_cnt = all_req(8); cap_code = '0;
        run("R2");
        check("R2", "ctx1 count", 64'(grant_cnt[7:4]), 64'd0);
        // R2: leftover flows down the chain
        req_cnt = '0; req_cnt[3:0] = 4'd3; req_cnt[7:4] = 4'd2; req_cnt[31:28] = 4'd8;
        run("R2");
        check("R2", "ctx7 count", 64'(grant_cnt[31:28]), 64'd3);

        // R3: each cap code
        for (int c = 0; c < 4; c++) begin
            req_cnt = all_req(8);
            for (int t = 0; t < NT; t++) cap_code[t*2 +: 2] = 2'(c);
            run("R3");
        end
        cap_code = 16'b11_10_01_00_11_10_01_00;
        req_cnt = all_req(5);
        run("R3");

        // R4: lowest-numbered free units go first
        cap_code = '0; req_cnt = '0; req_cnt[3:0] = 4'd2; busy = 8'b0000_0101;
        run("R4");
        check("R4", "unit1 owner valid", 64'(unit_vld), 64'b0000_1010);

        // R5: busy units withheld
        req_cnt = all_req(8); busy = 8'hF0;
        run("R5");
        busy = 8'hFF;
        run("R5");
        check("R5", "all busy", 64'(unit_vld), 64'd0);
        busy = '0;

        // R6: partitioned connection
        limited = 1'b1; req_cnt = all_req(8);
        run("R6");
        req_cnt = '0; req_cnt[7:4] = 4'd8; req_cnt[11:8] = 4'd1;
        run("R6");
        cap_code = 16'hFFFF; req_cnt = all_req(8); busy = 8'b0001_0001;
        run("R6");
        limited = 1'b0; busy = '0; cap_code = '0;

        // R7: random patterns across all controls
        for (int i = 0; i < 3000; i++) begin
            for (int t = 0; t < NT; t++) req_cnt[t*4 +: 4] = 4'($urandom_range(0, 8));
            cap_code = 16'($urandom);
            limited  = 1'($urandom);
            busy     = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
            if (i == 1500) rst_n = 1'b0;
            if (i == 1502) rst_n = 1'b1;
            run("R7");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule